// File: doc/BRIEF.md
# Variable-Page-Size Translation Buffer with Access Checks

This block is a small, fully associative address translation buffer for the data side of a processor. Each slot holds a virtual tag and a 32-bit translation word. The word carries a physical page number, a page-size code, a cache-mode code, a supervisor-protect bit, separate read, write and execute enables, and a lock bit. Each slot sets its own compare width from its page-size code. Pages of 1 KB, 4 KB, 8 KB and 1 MB can therefore sit side by side in the same buffer.

Lookup is purely combinational. In the same cycle, the caller gets the hit flag, the translated address, the cache mode, a multi-match flag and an access-error flag. When a page walker or refill agent has a new translation, it presents it on a valid/ready write port. The block then picks a slot:

- an empty slot is used first;
- otherwise the least recently used slot that is not locked is replaced.

A lookup marked valid that hits an unlocked slot refreshes that slot's recency. A hit on a locked slot refreshes nothing.

The write port never applies back-pressure: `wr_ready` is always high, and a beat is taken on every cycle where `wr_valid` is high. If every slot is both filled and locked, the beat is still consumed. Nothing is stored, and `alloc_fail` pulses instead.

Top module: `vpage_tlb`

## Requirements
- R1: After reset every slot is empty. Every lookup then misses, and a missing lookup drives `lk_pa` to zero, `lk_err` low, `lk_multi` low and `lk_cmode` to zero.
- R2: A slot hits when its stored tag equals the lookup address over the bits chosen by its page-size code (word bits 9..8). Code 00 is a 1 MB page and compares address bits 31..20. Code 01 is a 4 KB page and compares bits 31..12. Code 10 is an 8 KB page and compares bits 31..13. Code 11 is a 1 KB page and compares bits 31..10.
- R3: On a hit, `lk_pa` takes the compared bit positions from the slot's physical page number (word bits 31..10). All lower bits come from `lk_va`.
- R4: On a hit, `lk_cmode` returns the slot's cache-mode field (word bits 7..6). The codes are: 00 cacheable write-through, 01 cacheable copy-back, 10 non-cacheable precise, 11 non-cacheable imprecise.
- R5: A hit with `lk_user` high on a slot whose supervisor-protect bit (word bit 5) is set raises `lk_err`.
- R6: On a hit, `lk_acc` selects the enable that is checked, and a cleared enable raises `lk_err`. The codes are: 00 data read, which needs word bit 4; 01 data write, which needs word bit 3; 10 instruction fetch, which needs word bit 2; 11 probe, which checks no enable.
- R7: When several slots match, `lk_multi` goes high and the lowest-numbered matching slot supplies every result.
- R8: A write fills the lowest-numbered empty slot if one exists. Otherwise it replaces the least recently used unlocked slot. A slot's recency is refreshed when it is written, and when a lookup with `lk_valid` high hits it.
- R9: A slot written with the lock bit (word bit 1) set is never replaced. If all slots are full and locked, the write is dropped and `alloc_fail` is high for exactly the cycle after the write beat.
- R10: Neither a valid lookup that hits a locked slot nor any lookup with `lk_valid` low changes which slot is replaced next.
- R11: When a valid lookup and a write beat fall in the same cycle, the lookup returns the contents from before the write. The victim is chosen from the recency order held at the start of that cycle.
- R12: `wr_ready` is always high. A slot written on a clock edge is visible to lookups from that edge onward. Word bit 0 is reserved and is stored as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup is a real access (allows recency refresh) |
| lk_va | input | 32 | Lookup virtual address |
| lk_user | input | 1 | Access is made in user mode |
| lk_acc | input | 2 | Access type code (see R6) |
| lk_hit | output | 1 | A slot matched |
| lk_multi | output | 1 | More than one slot matched |
| lk_pa | output | 32 | Translated physical address |
| lk_cmode | output | 2 | Cache mode of the selected slot |
| lk_err | output | 1 | Permission or protection violation |
| wr_valid | input | 1 | Write beat offered |
| wr_ready | output | 1 | Write beat accepted |
| wr_va | input | 32 | Virtual address of the new translation (bits 31..10 stored) |
| wr_data | input | 32 | Translation word |
| alloc_fail | output | 1 | Previous write beat found no replaceable slot |

## Verification
A lookup that refreshes recency and a write that must choose a victim can land on the same clock edge. The sharp case is a valid lookup hitting the very slot that is oldest at that moment. The bench provokes this case by raising `lk_valid` and `wr_valid` together. It then judges two things. First, the lookup in that cycle must still report the old slot. Second, the old slot must have been replaced, and the next write must go to the following slot in the old recency order. Before this, locked-slot hits and probes with `lk_valid` low are run between writes, and each must leave the eviction order unchanged.

// File: rtl/vpage_tlb_pkg.sv
package vpage_tlb_pkg;

  localparam int VA_W  = 32;
  localparam int OFS_W = 10;
  localparam int TAG_W = VA_W - OFS_W;

  // Translation word; field positions fixed by the write-port encoding.
  typedef struct packed {
    logic [TAG_W-1:0] ppn;
    logic [1:0]       psize;
    logic [1:0]       cmode;
    logic             sprot;
    logic             rd_ok;
    logic             wr_ok;
    logic             ex_ok;
    logic             lock;
    logic             rsvd;
  } tlb_word_t;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_PROBE = 2'b11
  } acc_e;

  // Mask over VA[31:10] selecting the bits that take part in the compare.
  function automatic logic [TAG_W-1:0] tag_mask(input logic [1:0] psize);
    logic [3:0] drop;
    case (psize)
      2'b00:   drop = 4'd10;
      2'b01:   drop = 4'd2;
      2'b10:   drop = 4'd3;
      default: drop = 4'd0;
    endcase
    return {TAG_W{1'b1}} << drop;
  endfunction

  function automatic logic [VA_W-1:0] join_pa(input tlb_word_t w,
                                              input logic [VA_W-1:0] va);
    logic [VA_W-1:0] m;
    m = {tag_mask(w.psize), {OFS_W{1'b0}}};
    return ({w.ppn, {OFS_W{1'b0}}} & m) | (va & ~m);
  endfunction

endpackage

// File: rtl/vpage_tlb_entries.sv
module vpage_tlb_entries
  import vpage_tlb_pkg::*;
#(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  tlb_word_t        wr_word,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [N-1:0]     valid_o,
  output logic [N-1:0]     lock_o,
  output logic [N-1:0]     match_o,
  output tlb_word_t        word_o [N]
);

  tlb_word_t clean_word;

  always_comb begin
    clean_word      = wr_word;
    clean_word.rsvd = 1'b0;
  end

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    tlb_word_t        w_q;
    logic             sel;

    assign sel = wr_en && (wr_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   v_q <= 1'b0;
      else if (sel) v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        t_q <= wr_tag;
        w_q <= clean_word;
      end
    end

    assign valid_o[g] = v_q;
    assign lock_o[g]  = v_q & w_q.lock;
    assign match_o[g] = v_q && (((t_q ^ lk_tag) & tag_mask(w_q.psize)) == '0);
    assign word_o[g]  = w_q;
  end

  // R12: a slot written on an edge is occupied afterwards
  a_r12_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_o[$past(wr_idx)]);

endmodule

// File: rtl/vpage_tlb_lookup.sv
module vpage_tlb_lookup
  import vpage_tlb_pkg::*;
#(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    match_i,
  input  tlb_word_t       word_i [N],
  input  logic [VA_W-1:0] va,
  input  logic            user,
  input  logic [1:0]      acc,
  output logic            hit,
  output logic            multi,
  output logic [IW-1:0]   idx,
  output logic            hit_lock,
  output logic [VA_W-1:0] pa,
  output logic [1:0]      cmode,
  output logic            err
);

  tlb_word_t sel;
  logic      perm_bad;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_i[i]) idx = IW'(i);
    end
  end

  assign hit   = |match_i;
  assign multi = (match_i & (match_i - N'(1))) != '0;
  assign sel   = word_i[idx];

  always_comb begin
    case (acc_e'(acc))
      ACC_LOAD:  perm_bad = !sel.rd_ok;
      ACC_STORE: perm_bad = !sel.wr_ok;
      ACC_FETCH: perm_bad = !sel.ex_ok;
      default:   perm_bad = 1'b0;
    endcase
  end

  assign pa       = hit ? join_pa(sel, va) : '0;
  assign cmode    = hit ? sel.cmode : 2'b00;
  assign err      = hit && ((user && sel.sprot) || perm_bad);
  assign hit_lock = hit && sel.lock;

  // R7: chosen slot really matches and no lower slot does
  a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (match_i[idx] && ((match_i & ((N'(1) << idx) - N'(1))) == '0)));

  // R5: user access to a protected page is flagged
  a_r5_user_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && user && word_i[idx].sprot) |-> err);

  // R3: page offset below 1 KB always passes through
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (pa[OFS_W-1:0] == va[OFS_W-1:0]));

endmodule

// File: rtl/vpage_tlb_repl.sv
module vpage_tlb_repl #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  valid_i,
  input  logic [N-1:0]  lock_i,
  input  logic          hit_touch,
  input  logic          hit_lock,
  input  logic [IW-1:0] hit_idx,
  input  logic          wr_req,
  output logic          wr_fire,
  output logic [IW-1:0] victim_idx,
  output logic          alloc_fail
);

  // Age 0 is most recent; ages always form a permutation of 0..N-1.
  logic [IW-1:0] age_q   [N];
  logic [IW-1:0] age_mid [N];
  logic [IW-1:0] age_nxt [N];
  logic [N*IW-1:0] age_flat;

  logic          has_free, found, victim_ok;
  logic [IW-1:0] free_idx, lru_idx, lru_age, ref_a, ref_b;

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        has_free = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  always_comb begin
    found   = 1'b0;
    lru_idx = '0;
    lru_age = '0;
    for (int i = 0; i < N; i++) begin
      if (!lock_i[i] && (!found || age_q[i] > lru_age)) begin
        found   = 1'b1;
        lru_idx = IW'(i);
        lru_age = age_q[i];
      end
    end
  end

  assign victim_ok  = has_free || found;
  assign victim_idx = has_free ? free_idx : lru_idx;
  assign wr_fire    = wr_req && victim_ok;

  // Lookup refresh first, allocation refresh second.
  always_comb begin
    age_mid = age_q;
    ref_a   = age_q[hit_idx];
    if (hit_touch && !hit_lock) begin
      for (int j = 0; j < N; j++) begin
        if (IW'(j) == hit_idx)     age_mid[j] = '0;
        else if (age_q[j] < ref_a) age_mid[j] = age_q[j] + 1'b1;
      end
    end
  end

  always_comb begin
    age_nxt = age_mid;
    ref_b   = age_mid[victim_idx];
    if (wr_fire) begin
      for (int j = 0; j < N; j++) begin
        if (IW'(j) == victim_idx)    age_nxt[j] = '0;
        else if (age_mid[j] < ref_b) age_nxt[j] = age_mid[j] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
      alloc_fail <= 1'b0;
    end else begin
      age_q      <= age_nxt;
      alloc_fail <= wr_req && !victim_ok;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign age_flat[g*IW +: IW] = age_q[g];
  end

  // R9: a locked slot is never the target of a write
  a_r9_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !lock_i[victim_idx]);

  // R9: refusal only follows a write into a full, fully locked buffer
  a_r9_fail_cause: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fail |-> $past(wr_req && (&lock_i)));

  // R8: an empty slot is always preferred
  a_r8_free_first: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !(&valid_i)) |-> !valid_i[victim_idx]);

  // R10: locked hit without a write leaves the recency state alone
  a_r10_locked_hit_still: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_touch && hit_lock && !wr_req) |=> $stable(age_flat));

endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
  import vpage_tlb_pkg::*;
#(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_valid,
  input  logic [31:0] lk_va,
  input  logic        lk_user,
  input  logic [1:0]  lk_acc,
  output logic        lk_hit,
  output logic        lk_multi,
  output logic [31:0] lk_pa,
  output logic [1:0]  lk_cmode,
  output logic        lk_err,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [31:0] wr_va,
  input  logic [31:0] wr_data,
  output logic        alloc_fail
);

  logic [N-1:0]  valid_s, lock_s, match_s;
  tlb_word_t     word_s [N];
  logic [IW-1:0] hit_idx, victim_idx;
  logic          hit_lock, wr_fire;
  logic          unused_low;

  assign wr_ready   = 1'b1;
  assign unused_low = ^wr_va[OFS_W-1:0];

  vpage_tlb_entries #(.N(N)) u_entries (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_fire),
    .wr_idx  (victim_idx),
    .wr_tag  (wr_va[VA_W-1:OFS_W]),
    .wr_word (tlb_word_t'(wr_data)),
    .lk_tag  (lk_va[VA_W-1:OFS_W]),
    .valid_o (valid_s),
    .lock_o  (lock_s),
    .match_o (match_s),
    .word_o  (word_s)
  );

  vpage_tlb_lookup #(.N(N)) u_lookup (
    .clk      (clk),
    .rst_n    (rst_n),
    .match_i  (match_s),
    .word_i   (word_s),
    .va       (lk_va),
    .user     (lk_user),
    .acc      (lk_acc),
    .hit      (lk_hit),
    .multi    (lk_multi),
    .idx      (hit_idx),
    .hit_lock (hit_lock),
    .pa       (lk_pa),
    .cmode    (lk_cmode),
    .err      (lk_err)
  );

  vpage_tlb_repl #(.N(N)) u_repl (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_s),
    .lock_i     (lock_s),
    .hit_touch  (lk_valid && lk_hit),
    .hit_lock   (hit_lock),
    .hit_idx    (hit_idx),
    .wr_req     (wr_valid && wr_ready),
    .wr_fire    (wr_fire),
    .victim_idx (victim_idx),
    .alloc_fail (alloc_fail)
  );

  // R7: several matches imply a match
  a_r7_multi_has_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit);

  // R1: a miss never reports an error
  a_r1_miss_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> !lk_err);

endmodule

// File: tb/vpage_tlb_bench.sv
module vpage_tlb_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_user = 1'b0;
  logic [1:0]  lk_acc = 2'b00;
  logic        lk_hit, lk_multi, lk_err, wr_ready, alloc_fail;
  logic [31:0] lk_pa;
  logic [1:0]  lk_cmode;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_va = '0;
  logic [31:0] wr_data = '0;

  int n_chk = 0;
  int n_err = 0;
  logic last_fail;

  always #2 clk = ~clk;

  vpage_tlb u_vpage_tlb (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va),
    .lk_user(lk_user), .lk_acc(lk_acc), .lk_hit(lk_hit), .lk_multi(lk_multi),
    .lk_pa(lk_pa), .lk_cmode(lk_cmode), .lk_err(lk_err), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_va(wr_va), .wr_data(wr_data), .alloc_fail(alloc_fail)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] page_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   return 32'h0010_0000;
      2'b01:   return 32'h0000_1000;
      2'b10:   return 32'h0000_2000;
      default: return 32'h0000_0400;
    endcase
  endfunction

  function automatic logic [31:0] exp_pa(input logic [21:0] ppn, input logic [1:0] sz,
                                         input logic [31:0] va);
    logic [31:0] m;
    m = ~(page_bytes(sz) - 32'd1);
    return ({ppn, 10'b0} & m) | (va & ~m);
  endfunction

  function automatic logic [31:0] word(input logic [21:0] ppn, input logic [1:0] sz,
                                       input logic [1:0] cm, input logic [3:0] perm,
                                       input logic lk);
    return {ppn, sz, cm, perm, lk, 1'b1};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [31:0] va, input logic [31:0] data);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_va    = va;
    wr_data  = data;
    @(negedge clk);
    wr_valid  = 1'b0;
    last_fail = alloc_fail;
  endtask

  task automatic look(input logic [31:0] va, input logic user, input logic [1:0] acc);
    lk_valid = 1'b0;
    lk_va    = va;
    lk_user  = user;
    lk_acc   = acc;
    #1;
  endtask

  task automatic touch(input logic [31:0] va);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_va    = va;
    lk_acc   = 2'b11;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [31:0] va, input logic exp);
    look(va, 1'b0, 2'b11);
    chk(req, 64'(lk_hit), 64'(exp));
  endtask

  function automatic logic [31:0] reg4k(input int r);
    return 32'(r) << 12;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    do_reset();

    // R1 / R12: empty after reset
    for (int i = 0; i < 4; i++) begin
      look(32'h1234_5678 * 32'(i + 1), 1'b1, 2'(i));
      chk("R1", {lk_hit, lk_multi, lk_err, lk_cmode, lk_pa}, 64'd0);
    end
    chk("R12", 64'(wr_ready), 64'd1);
    chk("R9", 64'(alloc_fail), 64'd0);

    // Sweep: every page size x every protect/enable pattern, all access kinds.
    for (int k = 0; k < 64; k++) begin
      logic [1:0]  sz, cm;
      logic [3:0]  perm;
      logic [21:0] ppn;
      logic [31:0] base, bytes, va_in;
      sz    = 2'(k >> 4);
      perm  = 4'(k);
      cm    = 2'(k) ^ 2'(k >> 2);
      ppn   = 22'h155555 ^ 22'(k * 37);
      base  = 32'(k + 1) << 20;
      bytes = page_bytes(sz);
      wr(base | ((bytes - 1) & 32'hAAAA_A800), word(ppn, sz, cm, perm, 1'b0));
      chk("R9", 64'(last_fail), 64'd0);
      va_in = base | ((bytes - 1) & 32'h5555_5557);
      for (int u = 0; u < 2; u++) begin
        for (int a = 0; a < 4; a++) begin
          logic e_sp, e_pm;
          look(va_in, 1'(u), 2'(a));
          e_sp = (u == 1) && perm[3];
          e_pm = (a == 0 && !perm[2]) || (a == 1 && !perm[1]) || (a == 2 && !perm[0]);
          chk("R3", {lk_hit, lk_multi, lk_pa}, {1'b1, 1'b0, exp_pa(ppn, sz, va_in)});
          chk("R4", 64'(lk_cmode), 64'(cm));
          if (e_sp) chk("R5", 64'(lk_err), 64'd1);
          else      chk("R6", 64'(lk_err), 64'(e_pm));
        end
      end
      look(base + bytes, 1'b0, 2'b00);
      chk("R2", {lk_hit, lk_err, lk_cmode, lk_pa}, 64'd0);
      if (k >= 8) begin
        expect_hit("R8", 32'(k - 7) << 20, 1'b0);
        expect_hit("R8", 32'(k - 6) << 20, 1'b1);
      end
    end

    // Replacement order with locked slots.
    do_reset();
    expect_hit("R1", 32'(8) << 20, 1'b0);
    for (int i = 0; i < 8; i++)
      wr(reg4k(100 + i), word(22'(i * 3 + 1) << 2, 2'b01, 2'b00, 4'b0111, (i == 0) || (i == 4)));
    for (int i = 0; i < 8; i++) expect_hit("R8", reg4k(100 + i), 1'b1);
    touch(reg4k(101));
    touch(reg4k(104));
    wr(reg4k(200), word(22'h100, 2'b01, 2'b00, 4'b0111, 1'b0));
    expect_hit("R10", reg4k(102), 1'b0);
    expect_hit("R8", reg4k(101), 1'b1);
    expect_hit("R9", reg4k(100), 1'b1);
    expect_hit("R8", reg4k(200), 1'b1);
    wr(reg4k(201), word(22'h104, 2'b01, 2'b00, 4'b0111, 1'b0));
    expect_hit("R8", reg4k(103), 1'b0);
    wr(reg4k(202), word(22'h108, 2'b01, 2'b00, 4'b0111, 1'b0));
    expect_hit("R9", reg4k(105), 1'b0);
    expect_hit("R9", reg4k(104), 1'b1);
    look(reg4k(106), 1'b0, 2'b00);
    look(reg4k(106), 1'b1, 2'b10);
    wr(reg4k(203), word(22'h10C, 2'b01, 2'b00, 4'b0111, 1'b0));
    expect_hit("R10", reg4k(106), 1'b0);
    expect_hit("R10", reg4k(107), 1'b1);

    // Same-cycle refresh and allocation.
    @(negedge clk);
    lk_valid = 1'b1; lk_va = reg4k(107); lk_acc = 2'b11;
    wr_valid = 1'b1; wr_va = reg4k(204);
    wr_data  = word(22'h110, 2'b01, 2'b00, 4'b0111, 1'b0);
    #1;
    chk("R11", 64'(lk_hit), 64'd1);
    @(negedge clk);
    lk_valid = 1'b0; wr_valid = 1'b0;
    expect_hit("R11", reg4k(107), 1'b0);
    expect_hit("R12", reg4k(204), 1'b1);
    wr(reg4k(205), word(22'h114, 2'b01, 2'b00, 4'b0111, 1'b0));
    expect_hit("R11", reg4k(101), 1'b0);
    expect_hit("R11", reg4k(200), 1'b1);

    // Overlapping pages: lowest slot wins.
    do_reset();
    wr(32'h3000_0000, word(22'h2A5C00, 2'b00, 2'b10, 4'b0111, 1'b0));
    wr(32'h3000_5000, word(22'h001234, 2'b01, 2'b01, 4'b0111, 1'b0));
    look(32'h3000_5123, 1'b0, 2'b00);
    chk("R7", {lk_hit, lk_multi, lk_cmode, lk_pa},
        {1'b1, 1'b1, 2'b10, exp_pa(22'h2A5C00, 2'b00, 32'h3000_5123)});
    look(32'h3000_7000, 1'b0, 2'b00);
    chk("R7", {lk_hit, lk_multi, lk_pa}, {1'b1, 1'b0, exp_pa(22'h2A5C00, 2'b00, 32'h3000_7000)});
    wr(32'h3100_2000, word(22'h0ABC08, 2'b10, 2'b11, 4'b0111, 1'b0));
    wr(32'h3100_0000, word(22'h3FF000, 2'b00, 2'b00, 4'b0111, 1'b0));
    look(32'h3100_2ABC, 1'b0, 2'b00);
    chk("R7", {lk_hit, lk_multi, lk_cmode, lk_pa},
        {1'b1, 1'b1, 2'b11, exp_pa(22'h0ABC08, 2'b10, 32'h3100_2ABC)});

    // Fully locked buffer refuses a write.
    do_reset();
    for (int i = 0; i < 8; i++) begin
      wr(reg4k(400 + i), word(22'(i) << 2, 2'b01, 2'b00, 4'b0111, 1'b1));
      chk("R9", 64'(last_fail), 64'd0);
    end
    wr(reg4k(500), word(22'h200, 2'b01, 2'b00, 4'b0111, 1'b0));
    chk("R9", 64'(last_fail), 64'd1);
    @(negedge clk);
    chk("R9", 64'(alloc_fail), 64'd0);
    expect_hit("R9", reg4k(500), 1'b0);
    for (int i = 0; i < 8; i++) expect_hit("R9", reg4k(400 + i), 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule